// File: doc/BRIEF.md
# Multi-port GPIO controller with selectable pin drive

The block is a memory-mapped general-purpose I/O controller. It has a parameterised number of 8-pin ports, reached over a simple single-cycle 32-bit read/write bus. For each pin, software picks one of four modes: input, push-pull, open-drain or open-source. Software also sets an output latch bit and a pull-up disable bit. From these the block computes three pad-side controls per pin: the driven level, the output enable and the pull-up enable. The level at each pad input passes through a two-stage synchroniser, and software reads the synchronised value back.

Each port occupies a 0x1C-byte window, starting at address 0. A global control register follows the last port window, at byte address 0x54. Bit 0 of that register gates the whole block. While bit 0 is clear, no pad is driven and the block accepts only writes to the control register. Reads are combinational: `bus_rdata` reflects the addressed register in the same cycle as the read strobe. Writes take effect at the clock edge that samples the strobe.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every pin is in input mode, every output latch and pull-up disable bit is 0, and the block enable is 0. As a result, `pad_oe` is all 0, `pad_out` is all 0, `pad_pu_en` is all 1, and the mode, pull-up and control registers all read 0.
- R2: The mode register of a port is at offset 0x04. Pin n uses bits [2n+1:2n]. A read returns bits 15:0 as written, and bits 31:16 read as 0.
- R3: Mode code 01 (push-pull): when enabled, the pin has `pad_oe`=1 and `pad_out` equal to its output latch bit.
- R4: Mode code 10 (open-drain): when enabled, the pin has `pad_out`=0 and `pad_oe` equal to the inverse of its latch bit. The pin is driven only when the latch bit is low.
- R5: Mode code 11 (open-source): when enabled, the pin has `pad_out`=1 and `pad_oe` equal to its latch bit. The pin is driven only when the latch bit is high.
- R6: Mode code 00 (input): the pin has `pad_oe`=0 and `pad_out`=0.
- R7: The pull-up register of a port is at offset 0x18 and uses bits 7:0. A 1 in bit n disables the pull-up on pin n, so `pad_pu_en[n]` equals the inverse of that bit whether or not the block is enabled. A read returns bits 7:0, and the upper bits read as 0.
- R8: Offset 0x00 of a port is the data register. A write sets the 8 output latch bits from `bus_wdata[7:0]`. A read returns the synchronised pad levels in bits 7:0. A pad change made before clock edge k is first seen in the read after edge k+1, and not after edge k.
- R9: Port p is decoded at byte address p*0x1C plus the register offset. Global pin index p*8+n belongs to pin n of port p. Offsets 0x08, 0x0C, 0x10 and 0x14, unaligned addresses, and addresses that belong to no register all read 0, and writes to them change nothing.
- R10: The control register at 0x54 keeps `bus_wdata[0]` as the block enable, and reads back in bit 0. While the enable is 0, `pad_oe` and `pad_out` are all 0, and writes to port registers are ignored. The enable itself can always be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read strobe, 0 otherwise |
| pad_in | input | NPORTS*8 (24) | Pad input levels, asynchronous |
| pad_out | output | NPORTS*8 (24) | Level driven onto each pad |
| pad_oe | output | NPORTS*8 (24) | Output enable per pad |
| pad_pu_en | output | NPORTS*8 (24) | Pull-up enable per pad |

## Verification
The bench builds the block with its defaults: three ports and an 8-bit address. With these values the last port window ends at 0x53, so the control register at 0x54 sits directly next to it. Accesses on both sides of that boundary, and to the third port's own stride, are therefore tested. Random writes spread over all ports and all four mode codes. Directed cases cover the synchroniser latency, writes made while the block is disabled, and unaligned or unused offsets.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_PINS   = 8;
    localparam int MODE_W      = 2 * PORT_PINS;
    localparam int PORT_STRIDE = 'h1C;
    localparam int CTRL_ADDR   = 'h54;
    localparam int OFF_DATA    = 'h00;
    localparam int OFF_MODE    = 'h04;
    localparam int OFF_PUD     = 'h18;

    typedef enum logic [1:0] {
        MODE_IN = 2'b00,
        MODE_PP = 2'b01,
        MODE_OD = 2'b10,
        MODE_OS = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [PORT_PINS-1:0] dout;
        logic [MODE_W-1:0]    mode;
        logic [PORT_PINS-1:0] pud;
    } port_regs_t;

    typedef struct packed {
        logic en;
    } ctrl_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [1:0]   warm;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        if (st_q.warm != 2'd2) begin
            st_d.warm = st_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

    // R8: readback equals the pad level two edges earlier
    a_r8_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
(
    input  logic      en,
    input  pin_mode_e mode,
    input  logic      latch,
    output logic      drv_level,
    output logic      drv_oe
);
    always_comb begin
        drv_level = 1'b0;
        drv_oe    = 1'b0;
        if (en) begin
            unique case (mode)
                MODE_PP: begin
                    drv_level = latch;
                    drv_oe    = 1'b1;
                end
                MODE_OD: begin
                    drv_level = 1'b0;
                    drv_oe    = ~latch;
                end
                MODE_OS: begin
                    drv_level = 1'b1;
                    drv_oe    = latch;
                end
                default: begin
                    drv_level = 1'b0;
                    drv_oe    = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 hit,
    input  logic                 wr,
    input  logic [AW-1:0]        off,
    input  logic [MODE_W-1:0]    wdata,
    input  logic [PORT_PINS-1:0] din,
    output logic [31:0]          rdata,
    output logic [PORT_PINS-1:0] pad_out,
    output logic [PORT_PINS-1:0] pad_oe,
    output logic [PORT_PINS-1:0] pad_pu_en
);
    localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
    localparam logic [AW-1:0] A_MODE = AW'(OFF_MODE);
    localparam logic [AW-1:0] A_PUD  = AW'(OFF_PUD);

    port_regs_t regs_d, regs_q;
    logic       wr_ok;

    assign wr_ok = hit && wr && en;

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) begin
            if (off == A_DATA) regs_d.dout = wdata[PORT_PINS-1:0];
            if (off == A_MODE) regs_d.mode = wdata;
            if (off == A_PUD)  regs_d.pud  = wdata[PORT_PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = 32'd0;
        if (hit && !wr) begin
            if (off == A_DATA) rdata = {{(32-PORT_PINS){1'b0}}, din};
            if (off == A_MODE) rdata = {{(32-MODE_W){1'b0}}, regs_q.mode};
            if (off == A_PUD)  rdata = {{(32-PORT_PINS){1'b0}}, regs_q.pud};
        end
    end

    assign pad_pu_en = ~regs_q.pud;

    for (genvar n = 0; n < PORT_PINS; n++) begin : g_pin
        pin_mode_e pm;
        assign pm = pin_mode_e'(regs_q.mode[2*n+1:2*n]);

        gpio_pad_drive i_drive (
            .en       (en),
            .mode     (pm),
            .latch    (regs_q.dout[n]),
            .drv_level(pad_out[n]),
            .drv_oe   (pad_oe[n])
        );

        // R3: push-pull always drives
        a_r3_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (en && pm == MODE_PP) |-> (pad_oe[n] && pad_out[n] == regs_q.dout[n]));
        // R4: open-drain only ever pulls low
        a_r4_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
            (pm == MODE_OD && pad_oe[n]) |-> !pad_out[n]);
        // R5: open-source only ever pushes high
        a_r5_os_high_only: assert property (@(posedge clk) disable iff (!rst_n)
            (en && pm == MODE_OS) |-> (pad_out[n] && pad_oe[n] == regs_q.dout[n]));
        // R6: input pins are released
        a_r6_input_released: assert property (@(posedge clk) disable iff (!rst_n)
            (pm == MODE_IN) |-> (!pad_oe[n] && !pad_out[n]));
    end

    // R10: writes while disabled leave the port registers unchanged
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr && !en) |=> $stable(regs_q));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int AW     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NPORTS*PORT_PINS-1:0] pad_in,
    output logic [NPORTS*PORT_PINS-1:0] pad_out,
    output logic [NPORTS*PORT_PINS-1:0] pad_oe,
    output logic [NPORTS*PORT_PINS-1:0] pad_pu_en
);
    localparam int NPINS = NPORTS * PORT_PINS;

    ctrl_regs_t       ctrl_d, ctrl_q;
    logic [31:0]      addr32;
    logic             ctrl_hit;
    logic [NPINS-1:0] din_sync;
    logic [31:0]      port_rd [NPORTS];
    logic             unused_wdata_hi;

    assign addr32          = 32'(bus_addr);
    assign ctrl_hit        = bus_sel && (addr32 == 32'(CTRL_ADDR));
    assign unused_wdata_hi = ^bus_wdata[31:MODE_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_hit && bus_wr) begin
            ctrl_d.en = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    gpio_sync #(.W(NPINS)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (din_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int BASE = p * PORT_STRIDE;
        logic          hit;
        logic [AW-1:0] off;

        assign hit = bus_sel && (addr32 >= 32'(BASE)) && (addr32 < 32'(BASE + PORT_STRIDE));
        assign off = AW'(addr32 - 32'(BASE));

        gpio_port #(.AW(AW)) i_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ctrl_q.en),
            .hit      (hit),
            .wr       (bus_wr),
            .off      (off),
            .wdata    (bus_wdata[MODE_W-1:0]),
            .din      (din_sync[p*PORT_PINS +: PORT_PINS]),
            .rdata    (port_rd[p]),
            .pad_out  (pad_out[p*PORT_PINS +: PORT_PINS]),
            .pad_oe   (pad_oe[p*PORT_PINS +: PORT_PINS]),
            .pad_pu_en(pad_pu_en[p*PORT_PINS +: PORT_PINS])
        );
    end

    always_comb begin
        bus_rdata = 32'd0;
        for (int p = 0; p < NPORTS; p++) begin
            bus_rdata = bus_rdata | port_rd[p];
        end
        if (ctrl_hit && !bus_wr) begin
            bus_rdata = {31'd0, ctrl_q.en};
        end
    end

    // R10: nothing is driven while the block is off
    a_r10_no_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> (pad_oe == '0 && pad_out == '0));
    // R10: the enable follows a control write
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && bus_wr) |=> (ctrl_q.en == $past(bus_wdata[0])));
    // R9: reads outside a data access return zero
    a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == 32'd0));
endmodule

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NPINS = NP * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out, pad_oe, pad_pu_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0]  m_dout [NP];
    logic [15:0] m_mode [NP];
    logic [7:0]  m_pud  [NP];
    logic        m_en;

    gpio_ctrl i_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++;
                bad++;
                $display("FAIL watchdog act=%0d exp=<100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    // called at a negedge, completes before the next posedge
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        #1;
        bus_sel = 1'b0;
    endtask

    function automatic logic [1:0] exp_pin(input logic en, input logic [1:0] m, input logic q);
        // returns {level, oe}
        if (!en) return 2'b00;
        case (m)
            2'b01:   return {q, 1'b1};
            2'b10:   return {1'b0, ~q};
            2'b11:   return {1'b1, q};
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_pads(input string tag);
        logic [NPINS-1:0] eo, ee, ep;
        logic [1:0] r;
        for (int p = 0; p < NP; p++) begin
            for (int n = 0; n < 8; n++) begin
                r = exp_pin(m_en, m_mode[p][2*n +: 2], m_dout[p][n]);
                eo[p*8+n] = r[1];
                ee[p*8+n] = r[0];
                ep[p*8+n] = ~m_pud[p][n];
            end
        end
        chk({tag, " pad_out"}, 32'(pad_out), 32'(eo));
        chk({tag, " pad_oe"}, 32'(pad_oe), 32'(ee));
        chk({tag, " pad_pu_en R7"}, 32'(pad_pu_en), 32'(ep));
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h54) m_en = d[0];
        else if (m_en) begin
            for (int p = 0; p < NP; p++) begin
                if (a == 8'(p*28 + 0))  m_dout[p] = d[7:0];
                if (a == 8'(p*28 + 4))  m_mode[p] = d[15:0];
                if (a == 8'(p*28 + 24)) m_pud[p]  = d[7:0];
            end
        end
        bus_write(a, d);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        for (int p = 0; p < NP; p++) begin
            m_dout[p] = '0; m_mode[p] = '0; m_pud[p] = '0;
        end
        m_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pads("R1 reset");
        bus_read(8'h04, rd); chk("R1 mode reads 0", rd, 32'd0);
        bus_read(8'h18, rd); chk("R1 pud reads 0", rd, 32'd0);
        bus_read(8'h54, rd); chk("R1 ctrl reads 0", rd, 32'd0);
        @(negedge clk);

        // R10 writes ignored while disabled
        model_write(8'h04, 32'h0000_5555);
        bus_read(8'h04, rd); chk("R10 mode write ignored when off", rd, 32'd0);
        @(negedge clk);
        model_write(8'h54, 32'h1);
        bus_read(8'h54, rd); chk("R10 ctrl reads 1", rd, 32'd1);
        @(negedge clk);

        // R2 mode layout and upper bits
        model_write(8'h20, 32'hFFFF_ABCD);
        bus_read(8'h20, rd); chk("R2 mode readback", rd, 32'h0000_ABCD);
        @(negedge clk);

        // R3 R4 R5 R6: port 0 pins in modes in,pp,od,os repeated
        model_write(8'h04, 32'h0000_E4E4);
        model_write(8'h00, 32'h0000_00F0);
        check_pads("R3 R4 R5 R6 mixed low");
        model_write(8'h00, 32'h0000_000F);
        check_pads("R3 R4 R5 R6 mixed high");
        chk("R4 open-drain pin2 released when high", 32'(pad_oe[2]), 32'd0);
        chk("R5 open-source pin3 drives when high", 32'({pad_oe[3], pad_out[3]}), 32'd3);

        // R7 pull-up
        model_write(8'h18, 32'hFFFF_FFA5);
        bus_read(8'h18, rd); chk("R7 pud readback", rd, 32'h0000_00A5);
        @(negedge clk);
        check_pads("R7 pull-up");

        // R9 unused offset, unaligned, last port window
        model_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, rd); chk("R9 unused offset reads 0", rd, 32'd0);
        @(negedge clk);
        model_write(8'h05, 32'h0000_FFFF);
        bus_read(8'h04, rd); chk("R9 unaligned write ignored", rd, 32'h0000_E4E4);
        bus_read(8'h05, rd); chk("R9 unaligned read 0", rd, 32'd0);
        @(negedge clk);
        model_write(8'h3C, 32'h0000_5555);
        model_write(8'h38, 32'h0000_0081);
        check_pads("R9 port2 stride");
        bus_read(8'h50, rd); chk("R9 port2 pud at 0x50", rd, 32'd0);
        @(negedge clk);
        bus_read(8'h58, rd); chk("R9 beyond ctrl reads 0", rd, 32'd0);
        @(negedge clk);

        // R10 disable forces pads off and blocks writes
        model_write(8'h54, 32'h0);
        check_pads("R10 disabled");
        chk("R10 oe all off", 32'(pad_oe), 32'd0);
        model_write(8'h00, 32'h0000_00AA);
        model_write(8'h54, 32'h1);
        check_pads("R10 re-enabled latch kept");

        // R8 synchroniser latency
        pad_in = 24'h00005A;
        @(posedge clk); @(negedge clk);
        bus_read(8'h00, rd); chk("R8 one edge still old", rd, 32'd0);
        @(posedge clk); @(negedge clk);
        bus_read(8'h00, rd); chk("R8 two edges new", rd, 32'h5A);
        @(negedge clk);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int p, op;
            logic [31:0] d;
            logic [7:0] a;
            p = int'($urandom % NP);
            op = int'($urandom % 8);
            d = $urandom;
            case (op)
                0, 1, 2: a = 8'(p*28 + 0);
                3, 4:    a = 8'(p*28 + 4);
                5, 6:    a = 8'(p*28 + 24);
                default: begin a = 8'h54; d = {31'd0, ($urandom % 4) != 0}; end
            endcase
            model_write(a, d);
            check_pads("R3 R4 R5 R6 R7 random");
            bus_read(8'(p*28 + 4), rd); chk("R2 random mode", rd, 32'(m_mode[p]));
            @(negedge clk);
            bus_read(8'(p*28 + 24), rd); chk("R7 random pud", rd, 32'(m_pud[p]));
            @(negedge clk);
            if (it % 10 == 0) begin
                pad_in = NPINS'($urandom);
                @(posedge clk); @(posedge clk); @(negedge clk);
                for (int q = 0; q < NP; q++) begin
                    bus_read(8'(q*28), rd);
                    chk("R8 random data-in", rd, 32'(pad_in[q*8 +: 8]));
                    @(negedge clk);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule